// File: doc/BRIEF.md
# Write-back data cache with zero-install and discard

This block is a direct-mapped write-back data cache that sits between a processor request port and a line-wide memory port. Loads and stores are served from the resident line, and a miss fetches the whole line from memory before the access is completed. A dirty line that must leave its set is written back first.

Three maintenance commands act on whole lines. An install command makes a line present and all-zero without reading memory, and it marks the line as installed-clean. If such a line is evicted before any store touches it, it leaves silently and costs no memory write. A zero command also makes the line all-zero without a fetch, but it marks the line dirty, so the zeros reach memory on eviction. A discard command invalidates a matching line and drops its contents even when they are dirty. These commands let software avoid reading memory for freshly allocated storage and avoid writing back storage it has already released.

The processor side takes one request at a time through a valid/ready handshake. Every command completes with a one-cycle response pulse, which carries the word for loads. The memory side issues one read or one write request per line and waits for a response strobe.

Top module: `zc_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0. Command codes on `req_op` are 0 load, 1 store, 2 install, 3 zero, 4 discard.
- R2: A load or store that misses issues one memory read of line address `req_addr >> log2(WORDS)` and completes only after the line has arrived. The word returned is the one at offset `req_addr[log2(WORDS)-1:0]`, and word k of a line occupies bits `[k*WORD_W +: WORD_W]`.
- R3: A hit causes no memory request. Its `rsp_valid` is high during the second cycle after the accepting edge. Every command ends with exactly one single-cycle `rsp_valid` pulse, and `req_ready` is low from acceptance until that pulse.
- R4: A miss whose set holds a dirty line with another tag first writes that line back to line address {old tag, index} and then fetches the new line.
- R5: An install command issues no memory read, and the installed line reads back as all zeros.
- R6: A line that is installed-clean or clean is dropped on eviction without a memory write. An install that hits a clean line leaves it installed-clean.
- R7: A store to an installed-clean line makes it dirty, and its eviction writes the zero line with the stored word merged in.
- R8: A zero command issues no memory read, the line reads as zeros, and its eviction writes an all-zero line.
- R9: A discard whose tag matches invalidates the line without any memory traffic. Dirty data is lost, and the next access fetches the line from memory again.
- R10: A discard whose tag does not match the resident line leaves that line and its data unchanged.
- R11: An install or zero command to a set holding a dirty line with another tag writes that line back before zeroing, and still issues no read.
- R12: An install that hits a dirty line zeros it and keeps it dirty, so its eviction writes zeros.
- R13: A memory request holds its direction, address and write data until `mem_ready` accepts it. A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_op | input | 3 | Command code (see R1) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Load data, zero for other commands |
| mem_rd_req | output | 1 | Line read request |
| mem_wr_req | output | 1 | Line write request |
| mem_addr | output | ADDR_W-log2(WORDS) | Line address |
| mem_wdata | output | WORD_W*WORDS | Line write data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rsp_valid | input | 1 | Read data valid, or write done |
| mem_rsp_data | input | WORD_W*WORDS | Line read data |

## Verification
The bench builds the cache with a 12-bit address, four sets and four 32-bit words per line. With these values two addresses 0x40 apart share a set, so every eviction path can be forced with a handful of short addresses, and the bench memory model stays 1024 lines deep. The model answers each request two cycles after accepting it and counts reads and writes. This lets each scenario check that a memory access did or did not happen, and compare the exact line written back, in addition to the data returned to the processor.

// File: rtl/zc_pkg.sv
// Shared types for the zero-install cache: per-line state, command codes
// and controller sequencing states.
package zc_pkg;

    // Per-line state; LS_ZEROED marks zero data not yet stored to.
    typedef enum logic [1:0] {
        LS_INVALID = 2'd0,
        LS_CLEAN   = 2'd1,
        LS_DIRTY   = 2'd2,
        LS_ZEROED  = 2'd3
    } line_state_e;

    // Command codes carried on req_op.
    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_INSTALL = 3'd2,
        OP_ZERO    = 3'd3,
        OP_DISCARD = 3'd4
    } cmd_op_e;

    // Controller sequencing.
    typedef enum logic [2:0] {
        CS_IDLE,
        CS_LOOKUP,
        CS_WB_REQ,
        CS_WB_WAIT,
        CS_FILL_REQ,
        CS_FILL_WAIT
    } ctrl_state_e;

endpackage

// File: rtl/zc_tag_store.sv
// Tag and line-state array, one entry per set.
// Assumes one read/write index per cycle; read is combinational.
// Reset clears every state to invalid; tags are left as they are.
module zc_tag_store
    import zc_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int TAG_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] idx,
    output logic [TAG_W-1:0]        rd_tag,
    output line_state_e             rd_state,
    input  logic                    wr_en,
    input  logic [TAG_W-1:0]        wr_tag,
    input  line_state_e             wr_state
);

    logic [TAG_W-1:0] tag_arr [SETS];
    line_state_e      st_arr  [SETS];

    // Update the tag and state of the indexed set; invalidate all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                st_arr[s] <= LS_INVALID;
            end
        end else if (wr_en) begin
            st_arr[idx]  <= wr_state;
            tag_arr[idx] <= wr_tag;
        end
    end

    assign rd_tag   = tag_arr[idx];
    assign rd_state = st_arr[idx];

endmodule

// File: rtl/zc_data_store.sv
// Line data array. One indexed set is read combinationally. It can be
// rewritten whole (fill or zeroing) or have one word merged (store).
// Assumes a line write and a word write are never requested together;
// if both are, the line write wins.
module zc_data_store #(
    parameter int SETS   = 64,
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic [$clog2(SETS)-1:0]  idx,
    output logic [WORD_W*WORDS-1:0]  rd_line,
    input  logic                     line_we,
    input  logic [WORD_W*WORDS-1:0]  line_wdata,
    input  logic                     word_we,
    input  logic [$clog2(WORDS)-1:0] word_sel,
    input  logic [WORD_W-1:0]        word_wdata
);

    localparam int OFF_W  = $clog2(WORDS);
    localparam int LINE_W = WORD_W * WORDS;

    logic [LINE_W-1:0] lines [SETS];
    logic [LINE_W-1:0] merged;
    logic [LINE_W-1:0] next_line;

    assign rd_line = lines[idx];

    // Merge the store word into the current line, one lane per word.
    for (genvar w = 0; w < WORDS; w++) begin : g_merge
        assign merged[w*WORD_W +: WORD_W] =
            (word_we && word_sel == OFF_W'(w)) ? word_wdata
                                               : rd_line[w*WORD_W +: WORD_W];
    end

    assign next_line = line_we ? line_wdata : merged;

    // Write the selected set when any write is requested.
    always_ff @(posedge clk) begin
        if (line_we || word_we) begin
            lines[idx] <= next_line;
        end
    end

endmodule

// File: rtl/zc_ctrl.sv
// Cache controller. It accepts one request, looks it up against the
// indexed set, sequences the write-back and fill transfers, updates the
// tag and data stores, and produces one response pulse per request.
// Assumes tag/data reads are combinational from the latched index.
module zc_ctrl
    import zc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int SETS   = 64
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    output logic                                    req_ready,
    input  logic [2:0]                              req_op,
    input  logic [ADDR_W-1:0]                       req_addr,
    input  logic [WORD_W-1:0]                       req_wdata,
    output logic                                    rsp_valid,
    output logic [WORD_W-1:0]                       rsp_rdata,
    output logic                                    mem_rd_req,
    output logic                                    mem_wr_req,
    output logic [ADDR_W-$clog2(WORDS)-1:0]         mem_addr,
    output logic [WORD_W*WORDS-1:0]                 mem_wdata,
    input  logic                                    mem_ready,
    input  logic                                    mem_rsp_valid,
    input  logic [WORD_W*WORDS-1:0]                 mem_rsp_data,
    output logic [$clog2(SETS)-1:0]                 idx,
    input  logic [ADDR_W-$clog2(SETS)-$clog2(WORDS)-1:0] rd_tag,
    input  line_state_e                             rd_state,
    output logic                                    ts_we,
    output logic [ADDR_W-$clog2(SETS)-$clog2(WORDS)-1:0] ts_tag,
    output line_state_e                             ts_state,
    input  logic [WORD_W*WORDS-1:0]                 rd_line,
    output logic                                    ds_line_we,
    output logic [WORD_W*WORDS-1:0]                 ds_line_wdata,
    output logic                                    ds_word_we,
    output logic [$clog2(WORDS)-1:0]                ds_word_sel,
    output logic [WORD_W-1:0]                       ds_word_wdata
);

    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORD_W * WORDS;

    ctrl_state_e       st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        op_q;
    logic [WORD_W-1:0] wdata_q;
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_rdata_q;

    cmd_op_e           op_e;
    logic [TAG_W-1:0]  tag;
    logic [OFF_W-1:0]  off;
    logic              hit;
    logic              victim_dirty;
    logic              finish;
    logic [WORD_W-1:0] sel_word;

    assign op_e         = cmd_op_e'(op_q);
    assign idx          = addr_q[OFF_W +: IDX_W];
    assign tag          = addr_q[ADDR_W-1 -: TAG_W];
    assign off          = addr_q[OFF_W-1:0];
    assign hit          = (rd_state != LS_INVALID) && (rd_tag == tag);
    assign victim_dirty = (rd_state == LS_DIRTY) && !hit;
    assign sel_word     = rd_line[off*WORD_W +: WORD_W];

    assign req_ready     = (st_q == CS_IDLE);
    assign rsp_valid     = rsp_valid_q;
    assign rsp_rdata     = rsp_rdata_q;
    assign ds_word_sel   = off;
    assign ds_word_wdata = wdata_q;

    // Next state, store updates and memory requests for the current step.
    always_comb begin
        st_d          = st_q;
        finish        = 1'b0;
        ts_we         = 1'b0;
        ts_tag        = tag;
        ts_state      = LS_INVALID;
        ds_line_we    = 1'b0;
        ds_line_wdata = '0;
        ds_word_we    = 1'b0;
        mem_rd_req    = 1'b0;
        mem_wr_req    = 1'b0;
        mem_addr      = {tag, idx};
        mem_wdata     = rd_line;
        case (st_q)
            CS_IDLE: begin
                if (req_valid) st_d = CS_LOOKUP;
            end
            CS_LOOKUP: begin
                case (op_e)
                    OP_LOAD, OP_STORE: begin
                        if (hit) begin
                            finish = 1'b1;
                            if (op_e == OP_STORE) begin
                                ds_word_we = 1'b1;
                                ts_we      = 1'b1;
                                ts_state   = LS_DIRTY;
                            end
                        end else if (victim_dirty) begin
                            st_d = CS_WB_REQ;
                        end else begin
                            st_d = CS_FILL_REQ;
                        end
                    end
                    OP_INSTALL, OP_ZERO: begin
                        if (victim_dirty) begin
                            st_d = CS_WB_REQ;
                        end else begin
                            finish     = 1'b1;
                            ds_line_we = 1'b1;
                            ts_we      = 1'b1;
                            if (op_e == OP_ZERO || (hit && rd_state == LS_DIRTY))
                                ts_state = LS_DIRTY;
                            else
                                ts_state = LS_ZEROED;
                        end
                    end
                    OP_DISCARD: begin
                        finish = 1'b1;
                        if (hit) begin
                            ts_we    = 1'b1;
                            ts_state = LS_INVALID;
                        end
                    end
                    default: finish = 1'b1;
                endcase
                if (finish) st_d = CS_IDLE;
            end
            CS_WB_REQ: begin
                mem_wr_req = 1'b1;
                mem_addr   = {rd_tag, idx};
                if (mem_ready) st_d = CS_WB_WAIT;
            end
            CS_WB_WAIT: begin
                mem_addr = {rd_tag, idx};
                if (mem_rsp_valid) begin
                    ts_we    = 1'b1;
                    ts_tag   = rd_tag;
                    ts_state = LS_INVALID;
                    st_d     = CS_LOOKUP;
                end
            end
            CS_FILL_REQ: begin
                mem_rd_req = 1'b1;
                if (mem_ready) st_d = CS_FILL_WAIT;
            end
            CS_FILL_WAIT: begin
                if (mem_rsp_valid) begin
                    ds_line_we    = 1'b1;
                    ds_line_wdata = mem_rsp_data;
                    ts_we         = 1'b1;
                    ts_state      = LS_CLEAN;
                    st_d          = CS_LOOKUP;
                end
            end
            default: st_d = CS_IDLE;
        endcase
    end

    // Sequencing state and the single-cycle response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= CS_IDLE;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            st_q        <= st_d;
            rsp_valid_q <= finish;
            if (finish)
                rsp_rdata_q <= (op_e == OP_LOAD) ? sel_word : '0;
        end
    end

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            op_q    <= '0;
            wdata_q <= '0;
        end else if (req_valid && req_ready) begin
            addr_q  <= req_addr;
            op_q    <= req_op;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/zc_cache.sv
// Top of the direct-mapped write-back cache with zero-install, zero and
// discard commands. Wires the controller to the tag and data stores.
// Assumes WORDS and SETS are powers of two, each at least 2.
module zc_cache
    import zc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int SETS   = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [2:0]                      req_op,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [WORD_W-1:0]               req_wdata,
    output logic                            rsp_valid,
    output logic [WORD_W-1:0]               rsp_rdata,
    output logic                            mem_rd_req,
    output logic                            mem_wr_req,
    output logic [ADDR_W-$clog2(WORDS)-1:0] mem_addr,
    output logic [WORD_W*WORDS-1:0]         mem_wdata,
    input  logic                            mem_ready,
    input  logic                            mem_rsp_valid,
    input  logic [WORD_W*WORDS-1:0]         mem_rsp_data
);

    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORD_W * WORDS;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  rd_tag, ts_tag;
    line_state_e       rd_state, ts_state;
    logic              ts_we;
    logic [LINE_W-1:0] rd_line, ds_line_wdata;
    logic              ds_line_we, ds_word_we;
    logic [OFF_W-1:0]  ds_word_sel;
    logic [WORD_W-1:0] ds_word_wdata;

    zc_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .idx(idx), .rd_tag(rd_tag), .rd_state(rd_state),
        .ts_we(ts_we), .ts_tag(ts_tag), .ts_state(ts_state),
        .rd_line(rd_line), .ds_line_we(ds_line_we),
        .ds_line_wdata(ds_line_wdata), .ds_word_we(ds_word_we),
        .ds_word_sel(ds_word_sel), .ds_word_wdata(ds_word_wdata)
    );

    zc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .rd_tag(rd_tag), .rd_state(rd_state),
        .wr_en(ts_we), .wr_tag(ts_tag), .wr_state(ts_state)
    );

    zc_data_store #(.SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)) data_i (
        .clk(clk), .idx(idx), .rd_line(rd_line),
        .line_we(ds_line_we), .line_wdata(ds_line_wdata),
        .word_we(ds_word_we), .word_sel(ds_word_sel),
        .word_wdata(ds_word_wdata)
    );

endmodule

// File: rtl/zc_cache_chk.sv
// Port-level protocol checker for zc_cache, attached with bind.
// Tracks which command is outstanding, from acceptance to its response.
module zc_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            req_valid,
    input logic                            req_ready,
    input logic [2:0]                      req_op,
    input logic                            rsp_valid,
    input logic                            mem_rd_req,
    input logic                            mem_wr_req,
    input logic [ADDR_W-$clog2(WORDS)-1:0] mem_addr,
    input logic [WORD_W*WORDS-1:0]         mem_wdata,
    input logic                            mem_ready
);

    logic pend_nofetch;
    logic pend_discard;

    // Mark an outstanding install/zero or discard until its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_nofetch <= 1'b0;
            pend_discard <= 1'b0;
        end else if (req_valid && req_ready) begin
            pend_nofetch <= (req_op == 3'd2) || (req_op == 3'd3);
            pend_discard <= (req_op == 3'd4);
        end else if (rsp_valid) begin
            pend_nofetch <= 1'b0;
            pend_discard <= 1'b0;
        end
    end

    p_one_dir_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_ready) |=> (mem_rd_req && $stable(mem_addr)));

    p_wr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_ready) |=>
            (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata)));

    // Covers R5 and R8: install and zero never read memory.
    p_no_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_nofetch |-> !mem_rd_req);

    p_discard_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_discard |-> !(mem_rd_req || mem_wr_req));

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind zc_cache zc_cache_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .rsp_valid(rsp_valid), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready)
);

// File: tb/zc_cache_tb_top.sv
// Directed bench for zc_cache with a two-cycle line memory model.
module zc_cache_tb_top;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int SETS   = 4;
    localparam int LA_W   = 10;
    localparam int LINE_W = 128;

    localparam logic [2:0] C_LOAD = 3'd0, C_STORE = 3'd1, C_INST = 3'd2,
                           C_ZERO = 3'd3, C_DISC = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [WORD_W-1:0] rsp_rdata;
    logic              mem_rd_req, mem_wr_req;
    logic [LA_W-1:0]   mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_ready;
    logic              mem_rsp_valid;
    logic [LINE_W-1:0] mem_rsp_data;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    zc_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Initial memory content of a line: word k = A5000000 + la*16 + k.
    function automatic logic [LINE_W-1:0] pat(input logic [LA_W-1:0] la);
        logic [LINE_W-1:0] v;
        for (int w = 0; w < WORDS; w++)
            v[w*WORD_W +: WORD_W] = 32'hA500_0000 + ({22'd0, la} << 4) + w;
        return v;
    endfunction

    // Memory model: accepts when idle, responds two cycles later.
    logic [LINE_W-1:0] mdat [1 << LA_W];
    logic              mset [1 << LA_W];
    logic              busy;
    int                cnt;
    int                rd_cnt, wr_cnt;
    logic [LA_W-1:0]   last_wa;
    logic [LINE_W-1:0] last_wd;

    assign mem_ready = !busy;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= 0;
            rd_cnt <= 0;
            wr_cnt <= 0;
            for (int i = 0; i < (1 << LA_W); i++) mset[i] <= 1'b0;
        end else if (busy) begin
            if (cnt == 0) begin
                busy          <= 1'b0;
                mem_rsp_valid <= 1'b1;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (mem_rd_req) begin
            busy         <= 1'b1;
            cnt          <= 1;
            rd_cnt       <= rd_cnt + 1;
            mem_rsp_data <= mset[mem_addr] ? mdat[mem_addr] : pat(mem_addr);
        end else if (mem_wr_req) begin
            busy           <= 1'b1;
            cnt            <= 1;
            wr_cnt         <= wr_cnt + 1;
            mdat[mem_addr] <= mem_wdata;
            mset[mem_addr] <= 1'b1;
            last_wa        <= mem_addr;
            last_wd        <= mem_wdata;
        end
    end

    task automatic chk(input string req, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one command; return its data and the negedges until rsp_valid.
    task automatic do_req(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                          input logic [WORD_W-1:0] d,
                          output logic [WORD_W-1:0] q, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rsp_valid);
        q = rsp_rdata;
    endtask

    logic [WORD_W-1:0] q;
    int lat, r0, w0;

    task automatic t_reset;
        @(negedge clk);
        chk("R1 req_ready", 128'(req_ready), 128'(1));
        chk("R1 rsp_valid", 128'(rsp_valid), 128'(0));
        chk("R1 mem reqs", 128'({mem_rd_req, mem_wr_req}), 128'(0));
    endtask

    task automatic t_miss_hit;
        r0 = rd_cnt;
        do_req(C_LOAD, 12'h012, 0, q, lat);
        chk("R1/R2 first load fetches", 128'(rd_cnt - r0), 128'(1));
        chk("R2 miss data", 128'(q), 128'(32'hA500_0042));
        do_req(C_LOAD, 12'h011, 0, q, lat);
        chk("R3 hit no read", 128'(rd_cnt - r0), 128'(1));
        chk("R3 hit data", 128'(q), 128'(32'hA500_0041));
        chk("R3 hit latency", 128'(lat), 128'(2));
    endtask

    task automatic t_dirty_evict;
        logic [LINE_W-1:0] e;
        do_req(C_STORE, 12'h013, 32'hDEAD_0001, q, lat);
        w0 = wr_cnt; r0 = rd_cnt;
        do_req(C_LOAD, 12'h052, 0, q, lat);
        e = pat(10'h004); e[3*32 +: 32] = 32'hDEAD_0001;
        chk("R4 writeback count", 128'(wr_cnt - w0), 128'(1));
        chk("R4 writeback addr", 128'(last_wa), 128'(10'h004));
        chk("R4 writeback data", last_wd, e);
        chk("R4 refill data", 128'(q), 128'(32'hA500_0142));
        do_req(C_LOAD, 12'h013, 0, q, lat);
        chk("R4 stored word back", 128'(q), 128'(32'hDEAD_0001));
        chk("R6 clean victim silent", 128'(wr_cnt - w0), 128'(1));
    endtask

    task automatic t_install;
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(C_INST, 12'h100, 0, q, lat);
        do_req(C_LOAD, 12'h101, 0, q, lat);
        chk("R5 install reads zero", 128'(q), 128'(0));
        chk("R5 install no read", 128'(rd_cnt - r0), 128'(0));
        do_req(C_LOAD, 12'h140, 0, q, lat);
        chk("R6 installed line dropped", 128'(wr_cnt - w0), 128'(0));
        chk("R6 new line data", 128'(q), 128'(32'hA500_0500));
    endtask

    task automatic t_install_store;
        w0 = wr_cnt;
        do_req(C_INST, 12'h200, 0, q, lat);
        do_req(C_STORE, 12'h201, 32'hBEEF_0002, q, lat);
        do_req(C_LOAD, 12'h240, 0, q, lat);
        chk("R7 writes after store", 128'(wr_cnt - w0), 128'(1));
        chk("R7 write addr", 128'(last_wa), 128'(10'h080));
        chk("R7 write data", last_wd, 128'(32'hBEEF_0002) << 32);
    endtask

    task automatic t_zero;
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(C_ZERO, 12'h300, 0, q, lat);
        do_req(C_LOAD, 12'h302, 0, q, lat);
        chk("R8 zero reads zero", 128'(q), 128'(0));
        chk("R8 zero no read", 128'(rd_cnt - r0), 128'(0));
        do_req(C_LOAD, 12'h340, 0, q, lat);
        chk("R8 zero line written", 128'(wr_cnt - w0), 128'(1));
        chk("R8 write addr", 128'(last_wa), 128'(10'h0C0));
        chk("R8 write data", last_wd, '0);
    endtask

    task automatic t_discard;
        do_req(C_STORE, 12'h404, 32'hCAFE_0003, q, lat);
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(C_DISC, 12'h404, 0, q, lat);
        chk("R9 discard no traffic", 128'((rd_cnt - r0) + (wr_cnt - w0)), 128'(0));
        do_req(C_LOAD, 12'h404, 0, q, lat);
        chk("R9 refetch", 128'(rd_cnt - r0), 128'(1));
        chk("R9 dirty data lost", 128'(q), 128'(32'hA500_1010));
        chk("R9 no writeback", 128'(wr_cnt - w0), 128'(0));
    endtask

    task automatic t_discard_miss;
        do_req(C_STORE, 12'h508, 32'h1234_0004, q, lat);
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(C_DISC, 12'h548, 0, q, lat);
        do_req(C_LOAD, 12'h508, 0, q, lat);
        chk("R10 line kept", 128'(q), 128'(32'h1234_0004));
        chk("R10 no traffic", 128'((rd_cnt - r0) + (wr_cnt - w0)), 128'(0));
    endtask

    task automatic t_install_victim;
        logic [LINE_W-1:0] e;
        do_req(C_STORE, 12'h60C, 32'h5555_0005, q, lat);
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(C_INST, 12'h64C, 0, q, lat);
        e = pat(10'h183); e[31:0] = 32'h5555_0005;
        chk("R11 victim written", 128'(wr_cnt - w0), 128'(1));
        chk("R11 victim addr", 128'(last_wa), 128'(10'h183));
        chk("R11 victim data", last_wd, e);
        do_req(C_LOAD, 12'h64F, 0, q, lat);
        chk("R11 new line zero", 128'(q), 128'(0));
        chk("R11 no read", 128'(rd_cnt - r0), 128'(0));
    endtask

    task automatic t_install_dirty_hit;
        do_req(C_STORE, 12'h700, 32'h7777_0006, q, lat);
        w0 = wr_cnt;
        do_req(C_INST, 12'h700, 0, q, lat);
        do_req(C_LOAD, 12'h703, 0, q, lat);
        chk("R12 zeroed on hit", 128'(q), 128'(0));
        do_req(C_LOAD, 12'h740, 0, q, lat);
        chk("R12 stays dirty", 128'(wr_cnt - w0), 128'(1));
        chk("R12 write addr", 128'(last_wa), 128'(10'h1C0));
        chk("R12 write data", last_wd, '0);
        do_req(C_INST, 12'h740, 0, q, lat);
        w0 = wr_cnt;
        do_req(C_LOAD, 12'h780, 0, q, lat);
        chk("R6 clean hit install dropped", 128'(wr_cnt - w0), 128'(0));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_miss_hit();
        t_dirty_evict();
        t_install();
        t_install_store();
        t_zero();
        t_discard();
        t_discard_miss();
        t_install_victim();
        t_install_dirty_hit();
        repeat (3) @(negedge clk);
        chk("R13 idle memory port", 128'({mem_rd_req, mem_wr_req}), 128'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule